// File: doc/BRIEF.md
# Sign-sign adaptive coefficient counter

This block holds one adaptive weight of a mixed-signal least-mean-squares loop as a 12-bit two's complement register. Two comparator bits arrive each cycle: the sign of an error or gradient difference and the sign of a reference difference. On an update cycle the weight moves one count toward the direction given by the product of those signs. It stops at the ends of its range and does not wrap.

The register drives the digital side of a differential multiplying capacitor DAC. The weight's bitwise complement feeds the negative half. The eight upper bits, in offset form, are split into a coarse 4-bit segment and a fine 4-bit segment, and each segment is expanded to a 15-line thermometer word. The four low bits never reach the DAC. They only add integration depth, so the loop moves slowly. A programmable update divider sets how often steps are applied, which sets the learning rate. When the loop has settled, a load strobe copies the weight into a shift register, which sends it out serially, MSB first, with a valid flag.

Top module: `sign_lms_coef`

## Requirements
- R1: While rst_ni is low and after its release, coef_o is 0, coef_n_o is 12'hFFF and ser_valid_o is 0.
- R2: On an update cycle the weight increases by 1 when grad_sign_i equals ref_sign_i (1 means positive) and decreases by 1 when they differ.
- R3: The weight saturates: a step up from +2047 (12'h7FF) leaves it at +2047, and a step down from -2048 (12'h800) leaves it at -2048.
- R4: coef_n_o always equals 4095 minus coef_o read as unsigned, the bitwise complement.
- R5: With rate_sel_i = s held constant since reset release, updates occur on clock edges number 2^s, 2*2^s, ... counted from the first edge after release. The weight holds on all other edges.
- R6: With off = coef_o + 2048 (offset binary, 12 bits), dac_coarse_o[k] is 1 exactly when off[11:8] > k, and dac_fine_o[k] is 1 exactly when off[7:4] > k, for k = 0..14. Bits off[3:0] have no effect on either word.
- R7: A load_i sampled high at an edge captures the coef_o value present before that edge. From that edge on, ser_o presents bit 11 down to bit 0, one per clock, while ser_valid_o is high for exactly 12 cycles. A new load during shifting restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grad_sign_i | input | 1 | Sign of the gradient/error difference, 1 = positive |
| ref_sign_i | input | 1 | Sign of the reference difference, 1 = positive |
| rate_sel_i | input | 2 | Update period select, period = 2^rate_sel_i cycles |
| load_i | input | 1 | Capture weight into the serial readout register |
| coef_o | output | 12 | Weight, two's complement |
| coef_n_o | output | 12 | Complementary weight, 4095 - coef_o |
| dac_coarse_o | output | 15 | Thermometer word for the 16-unit columns |
| dac_fine_o | output | 15 | Thermometer word for the single units |
| ser_o | output | 1 | Serial readout data, MSB first |
| ser_valid_o | output | 1 | Serial readout data valid |

## Verification
The weight, its complement and both thermometer words all come from one register. They are therefore due one clock edge after an update cycle. The bench changes inputs on the falling edge, counts rising edges since reset release to decide which edges are update edges, and compares every output on the next falling edge against an arithmetic model of the weight. The serial port has the same one-edge latency: the MSB appears after the edge that sampled load_i, and each further bit appears one edge later. So the bench samples the weight before raising load_i, then checks one bit per falling edge for twelve cycles. Full up and down ramps at the fastest rate take the weight through every code, including both saturation points. Pseudo-random sign streams then run at every rate.

// File: rtl/sign_lms_pkg.sv
package sign_lms_pkg;

  // saturating single step on an unsigned view of a two's complement word
  function automatic logic [11:0] sat_step12(input logic [11:0] val, input logic up);
    if (up) return (val == 12'h7FF) ? val : val + 12'd1;
    else    return (val == 12'h800) ? val : val - 12'd1;
  endfunction

  function automatic int unsigned therm_width(input int unsigned seg_w);
    return (32'd1 << seg_w) - 32'd1;
  endfunction

endpackage

// File: rtl/sign_lms_rate_div.sv
module sign_lms_rate_div #(
  parameter int RATE_W = 2,
  localparam int CNT_W = (1 << RATE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_sel_i,
  output logic              en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'((32'd1 << rate_sel_i) - 32'd1);
    en_o = (cnt_q >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_o) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sign_lms_acc.sv
module sign_lms_acc #(
  parameter int COEF_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sign_a_i,
  input  logic              sign_b_i,
  output logic [COEF_W-1:0] coef_o
);
  localparam logic [COEF_W-1:0] MaxVal = {1'b0, {(COEF_W-1){1'b1}}};
  localparam logic [COEF_W-1:0] MinVal = {1'b1, {(COEF_W-1){1'b0}}};

  logic [COEF_W-1:0] coef_q, coef_d;
  logic up;

  always_comb begin
    up     = (sign_a_i == sign_b_i);   // product of signs is positive
    coef_d = coef_q;
    if (en_i) begin
      if (up && coef_q != MaxVal)       coef_d = coef_q + 1'b1;
      else if (!up && coef_q != MinVal) coef_d = coef_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_q <= '0;
    else         coef_q <= coef_d;
  end

  assign coef_o = coef_q;
endmodule

// File: rtl/sign_lms_therm.sv
module sign_lms_therm #(
  parameter int SEG_W = 4,
  localparam int THERM_W = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0]   bin_i,
  output logic [THERM_W-1:0] therm_o
);
  for (genvar k = 0; k < THERM_W; k++) begin : g_line
    assign therm_o[k] = (bin_i > SEG_W'(k));
  end
endmodule

// File: rtl/sign_lms_ser.sv
module sign_lms_ser #(
  parameter int COEF_W = 12,
  localparam int CNT_W = $clog2(COEF_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [COEF_W-1:0] data_i,
  output logic              ser_o,
  output logic              valid_o
);
  logic [COEF_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= CNT_W'(COEF_W);
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[COEF_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ser_o   = sh_q[COEF_W-1];
  assign valid_o = (cnt_q != '0);
endmodule

// File: rtl/sign_lms_coef.sv
module sign_lms_coef #(
  parameter int COEF_W = 12,
  parameter int SEG_W  = 4,
  parameter int RATE_W = 2,
  localparam int DAC_W   = 2 * SEG_W,
  localparam int THERM_W = (1 << SEG_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               grad_sign_i,
  input  logic               ref_sign_i,
  input  logic [RATE_W-1:0]  rate_sel_i,
  input  logic               load_i,
  output logic [COEF_W-1:0]  coef_o,
  output logic [COEF_W-1:0]  coef_n_o,
  output logic [THERM_W-1:0] dac_coarse_o,
  output logic [THERM_W-1:0] dac_fine_o,
  output logic               ser_o,
  output logic               ser_valid_o
);
  logic upd_en;
  logic [COEF_W-1:0]  coef;
  logic [DAC_W-1:0]   dac_word;
  logic [THERM_W-1:0] therm [2];

  sign_lms_rate_div #(.RATE_W(RATE_W)) i_div (
    .clk_i, .rst_ni, .rate_sel_i, .en_o(upd_en)
  );

  sign_lms_acc #(.COEF_W(COEF_W)) i_acc (
    .clk_i, .rst_ni, .en_i(upd_en),
    .sign_a_i(grad_sign_i), .sign_b_i(ref_sign_i), .coef_o(coef)
  );

  // offset binary: invert sign bit so the thermometer grows with the value
  assign dac_word = {~coef[COEF_W-1], coef[COEF_W-2 -: DAC_W-1]};

  for (genvar g = 0; g < 2; g++) begin : g_seg
    sign_lms_therm #(.SEG_W(SEG_W)) i_therm (
      .bin_i(dac_word[g*SEG_W +: SEG_W]), .therm_o(therm[g])
    );
  end

  sign_lms_ser #(.COEF_W(COEF_W)) i_ser (
    .clk_i, .rst_ni, .load_i, .data_i(coef), .ser_o, .valid_o(ser_valid_o)
  );

  assign coef_o       = coef;
  assign coef_n_o     = ~coef;
  assign dac_fine_o   = therm[0];
  assign dac_coarse_o = therm[1];
endmodule

// File: rtl/sign_lms_coef_chk.sv
module sign_lms_coef_chk #(
  parameter int COEF_W  = 12,
  parameter int THERM_W = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               upd_en,
  input logic               load_i,
  input logic [COEF_W-1:0]  coef_o,
  input logic [THERM_W-1:0] dac_coarse_o,
  input logic [THERM_W-1:0] dac_fine_o,
  input logic               ser_valid_o
);
  localparam logic [COEF_W-1:0] MaxVal = {1'b0, {(COEF_W-1){1'b1}}};
  localparam logic [COEF_W-1:0] MinVal = {1'b1, {(COEF_W-1){1'b0}}};

  // R2
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_o != $past(coef_o)) |->
      ((coef_o - $past(coef_o)) == COEF_W'(1) || ($past(coef_o) - coef_o) == COEF_W'(1)));

  // R3
  no_wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_o == MaxVal) |=> (coef_o != MinVal));

  // R3
  no_wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_o == MinVal) |=> (coef_o != MaxVal));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en |=> $stable(coef_o));

  // R6
  coarse_therm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dac_coarse_o + THERM_W'(1)) & dac_coarse_o) == '0);

  // R6
  fine_therm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dac_fine_o + THERM_W'(1)) & dac_fine_o) == '0);

  // R7
  load_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ser_valid_o);
endmodule

bind sign_lms_coef sign_lms_coef_chk #(.COEF_W(COEF_W), .THERM_W(THERM_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_en(upd_en), .load_i(load_i),
  .coef_o(coef_o), .dac_coarse_o(dac_coarse_o), .dac_fine_o(dac_fine_o),
  .ser_valid_o(ser_valid_o)
);

// File: tb/test_sign_lms_coef.sv
`timescale 1ns/1ps
module test_sign_lms_coef;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic g_s = 1'b0, r_s = 1'b0, ld = 1'b0;
  logic [1:0] rate = 2'd0;
  logic [11:0] coef, coef_n;
  logic [14:0] crs, fin;
  logic ser, ser_v;

  int tests = 0, fails = 0;
  int m = 0;            // model weight
  int ncyc = 0;         // edges since reset release
  int period = 1;
  logic [11:0] sh = '0;
  int scnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #2.5 clk = ~clk;

  sign_lms_coef i_sign_lms_coef (
    .clk_i(clk), .rst_ni(rst_n), .grad_sign_i(g_s), .ref_sign_i(r_s),
    .rate_sel_i(rate), .load_i(ld), .coef_o(coef), .coef_n_o(coef_n),
    .dac_coarse_o(crs), .dac_fine_o(fin), .ser_o(ser), .ser_valid_o(ser_v)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int off = m + 2048;
    chk("R2/R3 coef", int'(coef), m & 12'hFFF);
    chk("R4 coef_n", int'(coef_n), 4095 - (m & 12'hFFF));
    chk("R6 coarse", int'(crs), (1 << (off >> 8)) - 1);
    chk("R6 fine", int'(fin), (1 << ((off >> 4) & 15)) - 1);
    chk("R7 valid", int'(ser_v), (scnt != 0) ? 1 : 0);
    if (scnt != 0) chk("R7 ser bit", int'(ser), int'(sh[11]));
  endtask

  // at a falling edge: drive, run one rising edge, update model, check at next falling edge
  task automatic cyc(input logic a, input logic b, input logic l);
    g_s = a; r_s = b; ld = l;
    @(posedge clk);
    ncyc++;
    if (l) begin sh = m[11:0]; scnt = 12; end
    else if (scnt != 0) begin sh = sh << 1; scnt--; end
    if (ncyc % period == 0) begin   // R5
      if (a == b) begin if (m < 2047) m++; end
      else begin if (m > -2048) m--; end
    end
    @(negedge clk);
    ld = 1'b0;
    check_all();
  endtask

  task automatic do_reset(input logic [1:0] r);
    rst_n = 1'b0; rate = r;
    repeat (2) @(negedge clk);
    m = 0; scnt = 0; ncyc = 0; period = 1 << r;
    chk("R1 coef in reset", int'(coef), 0);
    chk("R1 coef_n in reset", int'(coef_n), 4095);
    chk("R1 valid in reset", int'(ser_v), 0);
    rst_n = 1'b1;
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    @(negedge clk);
    do_reset(2'd0);
    check_all();
    // full ramp up through every code into positive saturation (R2, R3, R6)
    for (int i = 0; i < 2100; i++) cyc(i[0], i[0], (i % 700) == 5);
    chk("R3 top saturation", int'(coef), 2047);
    // full ramp down into negative saturation
    for (int i = 0; i < 4150; i++) cyc(i[0], ~i[0], (i % 900) == 3);
    chk("R3 bottom saturation", int'(coef), 2048);
    // random signs with frequent loads, some restarting mid-shift (R7)
    for (int i = 0; i < 600; i++) begin
      logic a = next_bit();
      logic b = next_bit();
      cyc(a, b, (i % 17) == 0 || (i % 31) == 6);
    end
    // every slower rate (R5)
    for (int r = 1; r < 4; r++) begin
      @(negedge clk);
      do_reset(2'(r));
      check_all();
      for (int i = 0; i < 200; i++) cyc(1'b1, 1'b1, 1'b0);
      chk("R5 ramp at rate", int'(coef), 200 >> r);
      for (int i = 0; i < 800; i++) begin
        logic a = next_bit();
        logic b = next_bit();
        cyc(a, b, (i % 23) == 2);
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule